// File: doc/BRIEF.md
# Single-Key Stopwatch with Multiplexed Four-Digit Display

This block is a stopwatch core for a small board with one push-button and a four-digit common-anode seven-segment display. It keeps a time value of seconds (00 to 59) and hundredths (00 to 99) as four BCD digits. A clock enable that fires once every hundredth of a second advances the value. The enable comes from a counter sized by a parameter, and the system clock is never gated.

Repeated presses of the button step the unit through four modes: idle, run, halt and clear. The clear mode lasts one cycle. It zeroes the time and returns the unit to idle, so the next press starts a fresh run. The raw key is synchronised and debounced inside the block. The display is driven by time-multiplexing: one digit enable is active at a time, with active-low segment lines and a decimal point lit between seconds and hundredths.

Top module: `stopwatch_top`

## Requirements
- R1: In run mode, the time advances by exactly one hundredth for every TICK_CYCLES clock cycles spent in run mode. The tick interval starts again from zero each time run mode is entered. Outside run mode the time never advances.
- R2: Hundredths count from 00 to 99. A step from 99 gives 00 and adds one second.
- R3: Seconds count from 00 to 59. A step from 59.99 gives 00.00.
- R4: In halt mode the displayed time stays frozen for as long as the unit remains halted.
- R5: A press in halt mode clears both fields to zero and returns the unit to idle. The next press starts counting again from 00.00.
- R6: A press is accepted only after the synchronised key (active low) has stayed low for DEBOUNCE_CYCLES consecutive cycles. A shorter low pulse is ignored and leaves both the mode and the time unchanged.
- R7: A key held low for any length of time advances the mode by exactly one step. After an accepted press, a hold-off of HOLDOFF_CYCLES must pass and the key must return high before another press can be accepted.
- R8: The display scans its digits in the repeating order seconds-tens, seconds-units, hundredths-tens, hundredths-units. These are selected by digit enables 4'b1110, 4'b1101, 4'b1011 and 4'b0111. Each digit is shown for DWELL_CYCLES cycles, and exactly one enable is low at any time.
- R9: Segment lines are active low, with bit 7 = decimal point, bit 6 = g down to bit 0 = a. The codes for digits 0 to 9 are C0, F9, A4, B0, 99, 92, 82, F8, 80, 90 (hex), before the decimal point is applied.
- R10: The decimal point (bit 7 low) is lit only while the seconds-units digit is enabled.
- R11: Synchronous reset gives idle mode, time 00.00, and the first digit selected. On the first cycle after reset the outputs read enables 4'b1110 and segments C0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| keyN | input | 1 | Raw push-button, low when pressed, asynchronous |
| digitEnN | output | 4 | Digit enables, active low, bit 0 = seconds tens |
| segN | output | 8 | Segment lines, active low, bit 7 = dp, bits 6..0 = g..a |

## Verification
A wrong BCD digit or a missed carry appears on the segment lines within one scan period, which is four dwells. It does so as a code that does not match the expected digit for the number of ticks implied by the time spent in run mode. A stuck or skipped mode step changes how many ticks are accumulated, and a glitch that gets through the debounce starts a run. Either fault shows in the next halted readout. A broken scan sequencer shows within a few cycles, as an enable pattern out of order, a wrong dwell, or a decimal point on the wrong digit.

// File: rtl/sw_pkg.sv
package sw_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_HALT  = 2'd2,
    MODE_CLEAR = 2'd3
  } swMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic clear;
  } swStrobe_t;

  // active-low code, bit 7 = dp, bits 6..0 = g..a
  function automatic logic [7:0] segEncode(input logic [3:0] value, input logic pointOn);
    logic [6:0] lowCode;
    case (value)
      4'd0: lowCode = 7'h40;
      4'd1: lowCode = 7'h79;
      4'd2: lowCode = 7'h24;
      4'd3: lowCode = 7'h30;
      4'd4: lowCode = 7'h19;
      4'd5: lowCode = 7'h12;
      4'd6: lowCode = 7'h02;
      4'd7: lowCode = 7'h78;
      4'd8: lowCode = 7'h00;
      4'd9: lowCode = 7'h10;
      default: lowCode = 7'h7F;
    endcase
    return {~pointOn, lowCode};
  endfunction

endpackage

// File: rtl/sw_ctrl.sv
module sw_ctrl
  import sw_pkg::*;
#(
  parameter int TICK_CYCLES     = 1_000_000,
  parameter int DEBOUNCE_CYCLES = 1_000_000,
  parameter int HOLDOFF_CYCLES  = 2_000_000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      keyN,
  output swStrobe_t strobes,
  output swMode_e   mode
);

  localparam int TICK_W = $clog2(TICK_CYCLES + 1);
  localparam int DB_MAX = (DEBOUNCE_CYCLES > HOLDOFF_CYCLES) ? DEBOUNCE_CYCLES : HOLDOFF_CYCLES;
  localparam int DB_W   = $clog2(DB_MAX + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYCLES - 1);
  localparam logic [DB_W-1:0]   DEB_LAST  = DB_W'(DEBOUNCE_CYCLES - 1);
  localparam logic [DB_W-1:0]   HOLD_LAST = DB_W'(HOLDOFF_CYCLES - 1);

  typedef enum logic [1:0] {
    KEY_IDLE, KEY_CHECK, KEY_HOLD, KEY_RELEASE
  } keyState_e;

  logic keyMeta, keySync;
  keyState_e keyState;
  logic [DB_W-1:0] dbCnt;
  logic press;
  logic [TICK_W-1:0] tickCnt;

  // two-flop synchronizer, idle high
  always_ff @(posedge clk) begin
    if (rst) begin
      keyMeta <= 1'b1;
      keySync <= 1'b1;
    end else begin
      keyMeta <= keyN;
      keySync <= keyMeta;
    end
  end

  assign press = (keyState == KEY_CHECK) && !keySync && (dbCnt == DEB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      keyState <= KEY_IDLE;
      dbCnt    <= '0;
    end else begin
      case (keyState)
        KEY_IDLE: begin
          dbCnt <= '0;
          if (!keySync) keyState <= KEY_CHECK;
        end
        KEY_CHECK: begin
          if (keySync) begin
            keyState <= KEY_IDLE;
            dbCnt    <= '0;
          end else if (dbCnt == DEB_LAST) begin
            keyState <= KEY_HOLD;
            dbCnt    <= '0;
          end else begin
            dbCnt <= dbCnt + 1'b1;
          end
        end
        KEY_HOLD: begin
          if (dbCnt == HOLD_LAST) begin
            keyState <= KEY_RELEASE;
            dbCnt    <= '0;
          end else begin
            dbCnt <= dbCnt + 1'b1;
          end
        end
        default: begin
          dbCnt <= '0;
          if (keySync) keyState <= KEY_IDLE;
        end
      endcase
    end
  end

  // mode stepping; clear mode lasts one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_IDLE;
    end else if (mode == MODE_CLEAR) begin
      mode <= MODE_IDLE;
    end else if (press) begin
      mode <= swMode_e'(mode + 2'd1);
    end
  end

  // tick interval restarts on every entry into run
  always_ff @(posedge clk) begin
    if (rst || mode != MODE_RUN) begin
      tickCnt <= '0;
    end else if (tickCnt == TICK_LAST) begin
      tickCnt <= '0;
    end else begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign strobes.tick  = (mode == MODE_RUN) && (tickCnt == TICK_LAST);
  assign strobes.clear = (mode == MODE_CLEAR);

endmodule

// File: rtl/sw_datapath.sv
module sw_datapath
  import sw_pkg::*;
#(
  parameter int DWELL_CYCLES = 20_000
) (
  input  logic        clk,
  input  logic        rst,
  input  swStrobe_t   strobes,
  output logic [15:0] countBcd,
  output logic [3:0]  digitEnN,
  output logic [7:0]  segN
);

  localparam int NUM_DIGITS = 4;
  localparam int POS_W      = $clog2(NUM_DIGITS);
  localparam int DWELL_W    = $clog2(DWELL_CYCLES + 1);
  localparam logic [DWELL_W-1:0] DWELL_LAST = DWELL_W'(DWELL_CYCLES - 1);
  localparam logic [POS_W-1:0]   POINT_POS  = POS_W'(1);

  // digit 0 = hundredths units ... digit 3 = seconds tens
  logic [3:0] digitQ [NUM_DIGITS];
  logic [NUM_DIGITS:0] carry;

  assign carry[0] = strobes.tick;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    localparam logic [3:0] LIMIT = (i == NUM_DIGITS - 1) ? 4'd5 : 4'd9;
    assign carry[i+1] = carry[i] && (digitQ[i] == LIMIT);
    always_ff @(posedge clk) begin
      if (rst || strobes.clear) begin
        digitQ[i] <= 4'd0;
      end else if (carry[i]) begin
        digitQ[i] <= (digitQ[i] == LIMIT) ? 4'd0 : digitQ[i] + 4'd1;
      end
    end
  end

  assign countBcd = {digitQ[3], digitQ[2], digitQ[1], digitQ[0]};

  logic [DWELL_W-1:0] dwellCnt;
  logic [POS_W-1:0]   scanPos;
  logic [3:0]         shownValue;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwellCnt <= '0;
      scanPos  <= '0;
    end else if (dwellCnt == DWELL_LAST) begin
      dwellCnt <= '0;
      scanPos  <= scanPos + 1'b1;
    end else begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  // scan position 0 shows the most significant digit
  assign shownValue = digitQ[POS_W'(NUM_DIGITS - 1) - scanPos];

  always_ff @(posedge clk) begin
    if (rst) begin
      digitEnN <= 4'b1110;
      segN     <= segEncode(4'd0, 1'b0);
    end else begin
      digitEnN <= ~(4'b0001 << scanPos);
      segN     <= segEncode(shownValue, scanPos == POINT_POS);
    end
  end

endmodule

// File: rtl/stopwatch_top.sv
module stopwatch_top
  import sw_pkg::*;
#(
  parameter int TICK_CYCLES     = 1_000_000,
  parameter int DEBOUNCE_CYCLES = 1_000_000,
  parameter int HOLDOFF_CYCLES  = 2_000_000,
  parameter int DWELL_CYCLES    = 20_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       keyN,
  output logic [3:0] digitEnN,
  output logic [7:0] segN
);

  swStrobe_t   strobes;
  swMode_e     ctrlMode;
  logic [15:0] countBcd;
  logic        tickStb;
  logic        clearStb;

  sw_ctrl #(
    .TICK_CYCLES    (TICK_CYCLES),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .HOLDOFF_CYCLES (HOLDOFF_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .keyN   (keyN),
    .strobes(strobes),
    .mode   (ctrlMode)
  );

  sw_datapath #(
    .DWELL_CYCLES(DWELL_CYCLES)
  ) u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .countBcd(countBcd),
    .digitEnN(digitEnN),
    .segN    (segN)
  );

  assign tickStb  = strobes.tick;
  assign clearStb = strobes.clear;

endmodule

// File: rtl/stopwatch_checker.sv
module stopwatch_checker
  import sw_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [3:0]  digitEnN,
  input logic [7:0]  segN,
  input logic [15:0] countBcd,
  input swMode_e     mode,
  input logic        tickStb,
  input logic        clearStb
);

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
    $countones(~digitEnN) == 1); // R8

  AST_POINT_SECOND_DIGIT: assert property (@(posedge clk) disable iff (rst)
    segN[7] == (digitEnN != 4'b1101)); // R10

  AST_TICK_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    tickStb |-> mode == MODE_RUN); // R1

  AST_HUND_RANGE: assert property (@(posedge clk) disable iff (rst)
    countBcd[7:4] <= 4'd9 && countBcd[3:0] <= 4'd9); // R2

  AST_HUND_CARRY: assert property (@(posedge clk) disable iff (rst)
    (tickStb && countBcd[7:0] == 8'h99 && countBcd[15:8] != 8'h59)
      |=> countBcd[7:0] == 8'h00 && countBcd[15:8] == $past(countBcd[15:8]) + 8'h01
          || countBcd[7:0] == 8'h00 && $past(countBcd[11:8]) == 4'd9); // R2

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    countBcd[15:12] <= 4'd5 && countBcd[11:8] <= 4'd9); // R3

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tickStb && countBcd == 16'h5999) |=> countBcd == 16'h0000); // R3

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    mode == MODE_HALT |=> $stable(countBcd)); // R4

  AST_CLEAR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    clearStb |=> mode == MODE_IDLE && countBcd == 16'h0000); // R5

endmodule

bind stopwatch_top stopwatch_checker u_checker (
  .clk     (clk),
  .rst     (rst),
  .digitEnN(digitEnN),
  .segN    (segN),
  .countBcd(countBcd),
  .mode    (ctrlMode),
  .tickStb (tickStb),
  .clearStb(clearStb)
);

// File: tb/stopwatch_top_bench.sv
`timescale 1ns/1ps
module stopwatch_top_bench;

  localparam int TICK  = 8;
  localparam int DEB   = 4;
  localparam int HOLD  = 6;
  localparam int DWELL = 3;
  localparam int PRESS = 20;
  localparam int AFTER = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic keyN = 1'b1;
  logic [3:0] digitEnN;
  logic [7:0] segN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stopwatch_top #(
    .TICK_CYCLES(TICK), .DEBOUNCE_CYCLES(DEB),
    .HOLDOFF_CYCLES(HOLD), .DWELL_CYCLES(DWELL)
  ) u_stopwatch_top (
    .clk(clk), .rst(rst), .keyN(keyN), .digitEnN(digitEnN), .segN(segN)
  );

  // bench-side digit shapes, active high gfedcba
  function automatic logic [7:0] expSeg(input int value, input bit point);
    logic [6:0] lit;
    case (value)
      0: lit = 7'b0111111;
      1: lit = 7'b0000110;
      2: lit = 7'b1011011;
      3: lit = 7'b1001111;
      4: lit = 7'b1100110;
      5: lit = 7'b1101101;
      6: lit = 7'b1111101;
      7: lit = 7'b0000111;
      8: lit = 7'b1111111;
      default: lit = 7'b1101111;
    endcase
    return ~{point, lit};
  endfunction

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pressKey(input int holdLow);
    keyN = 1'b0;
    waitCycles(holdLow);
    keyN = 1'b1;
    waitCycles(AFTER);
  endtask

  // one full aligned scan; checks order, dwell and each digit's code
  task automatic readDisplay(input int ticks, input string req);
    int expDigit [4];
    logic [7:0] seen [4];
    logic [3:0] prevEn;
    int scanBad = 0;
    int badVal = 0;
    int hund = ticks % 100;
    int secs = (ticks / 100) % 60;
    expDigit[0] = secs / 10;
    expDigit[1] = secs % 10;
    expDigit[2] = hund / 10;
    expDigit[3] = hund % 10;
    prevEn = digitEnN;
    @(negedge clk);
    while (!(prevEn == 4'b0111 && digitEnN == 4'b1110)) begin
      prevEn = digitEnN;
      @(negedge clk);
    end
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < DWELL; d++) begin
        if (!(p == 0 && d == 0)) @(negedge clk);
        if (digitEnN != ~(4'b0001 << p)) begin
          scanBad++;
          badVal = digitEnN;
        end
        seen[p] = segN;
      end
    end
    @(negedge clk);
    if (digitEnN != 4'b1110) begin
      scanBad++;
      badVal = digitEnN;
    end
    check(scanBad == 0, "R8 scan order/dwell", badVal, 4'b1110);
    for (int p = 0; p < 4; p++) begin
      check(seen[p] == expSeg(expDigit[p], p == 1),
            $sformatf("%s R9 R10 digit %0d", req, p), seen[p], expSeg(expDigit[p], p == 1));
    end
  endtask

  // start, run for k ticks (plus half an interval), halt, verify
  task automatic timedRun(input int k, input int startHold, input string req);
    int dur = k * TICK + TICK / 2;
    pressKey(startHold);
    waitCycles(dur - (startHold + AFTER));
    pressKey(PRESS);
    readDisplay(k, req);
  endtask

  initial begin
    int sweep [8] = '{10, 99, 100, 101, 999, 1000, 5999, 6000};
    waitCycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R11: first cycle after reset
    check(digitEnN == 4'b1110, "R11 reset enables", digitEnN, 4'b1110);
    check(segN == 8'hC0, "R11 reset segments", segN, 8'hC0);
    readDisplay(0, "R11 reset value");

    // R6: short low pulse ignored, stays idle at 00.00
    keyN = 1'b0;
    waitCycles(2);
    keyN = 1'b1;
    waitCycles(200);
    readDisplay(0, "R6 glitch ignored");

    // R7: long hold starts exactly one step (a second step would halt early)
    timedRun(57, 300, "R1 R7 long press");
    // R4: halted value stays
    waitCycles(500);
    readDisplay(57, "R4 halt frozen");

    // R5: third press clears to idle
    pressKey(PRESS);
    waitCycles(100);
    readDisplay(0, "R5 cleared");

    timedRun(250, PRESS, "R2 carry");
    pressKey(PRESS);
    timedRun(6123, PRESS, "R3 wrap");
    pressKey(PRESS);

    foreach (sweep[i]) begin
      timedRun(sweep[i], PRESS, $sformatf("R1 R2 R3 sweep %0d", sweep[i]));
      pressKey(PRESS);
      if (i == 0) readDisplay(0, "R5 clear again");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCycles(195_000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule